// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the address stream for an interleaved DMA transfer between main memory and a scratchpad. A job is described by a total quadword count, a run length and a skip length (both in quadwords), a main-memory byte address, a scratchpad byte address and a direction bit. The block then issues one read/write address pair per clock cycle, one for each quadword. After every run of quadwords it moves the main-memory pointer forward over a gap of `skip` quadwords. The scratchpad pointer advances without gaps. The direction bit only decides which side is the read side and which is the write side. The address arithmetic is the same in both directions.

While the job runs, the block keeps a set of channel registers: the remaining count, the main-memory address and the scratchpad address. These are updated once per run and show their final values when the job ends. After the last beat the block waits a number of cycles proportional to the total count, then raises a one-cycle completion interrupt request. Data movement and bus arbitration happen outside this block.

Top module: `ilv_stride_agen`

## Requirements
- R1: While reset is high and after it is released, the block is idle: `busy`, `beat_valid` and `irq` are 0, and `chan_qwc`, `chan_mem` and `chan_spr` are 0.
- R2: A run length of 0 is treated as equal to the total count, so the whole job is one run and main-memory addresses are contiguous.
- R3: Each run moves min(run length, remaining) quadwords, one per cycle in consecutive cycles starting the cycle after `start` is sampled. `chan_qwc` holds the total at load and drops by the run size at the edge that ends each run.
- R4: The scratchpad-side address starts at `spr_addr` and increases by 16 on every beat, across run boundaries.
- R5: The main-memory-side address starts at `mem_addr` and increases by 16 inside a run. From the last beat of one run to the first beat of the next, it increases by 16 × (skip + 1).
- R6: With `dir`=1 (into scratchpad), `rd_addr` is the main-memory side and `wr_addr` is the scratchpad side. With `dir`=0 the roles swap.
- R7: When the job ends, `chan_qwc` is 0 and stays 0 until the next job.
- R8: `irq` is high for exactly one cycle per job.
- R9: Let N be the total count and t the cycle of the last beat. `irq` is high in cycle t + 2 + N × `DLY_PER_QW`. No beat is issued between the last beat and the end of the interrupt cycle.
- R10: A job with a total count of 0 issues no beat. Its `irq` is high two cycles after the cycle in which `start` was high.
- R11: `start` is ignored while `busy` is 1, from the acceptance cycle through the interrupt cycle. The job in progress keeps its configuration and its address stream.
- R12: `chan_mem` and `chan_spr` are loaded from `mem_addr` and `spr_addr` when a job is accepted. They change only at the edge that ends a run, advancing by 16 × (run + skip) and 16 × run respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, sampled while idle |
| dir | input | 1 | 1: memory to scratchpad, 0: scratchpad to memory |
| total_qwc | input | 16 | Total quadwords of the job |
| run_qwc | input | 16 | Quadwords per run (0 = whole job) |
| skip_qwc | input | 16 | Quadwords skipped in main memory after each run |
| mem_addr | input | 32 | Main-memory start byte address |
| spr_addr | input | 32 | Scratchpad start byte address |
| busy | output | 1 | Job in progress, including the delay and interrupt cycles |
| beat_valid | output | 1 | One quadword transfer this cycle |
| rd_addr | output | 32 | Read byte address of the current beat |
| wr_addr | output | 32 | Write byte address of the current beat |
| chan_mem | output | 32 | Channel main-memory address register |
| chan_spr | output | 32 | Channel scratchpad address register |
| chan_qwc | output | 16 | Channel remaining-count register |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The jobs tested cover several cases. A run length that divides the count and one that does not separate correct clamping of the last run from an over-read. A run length of zero and a run length larger than the count both have to collapse to a single contiguous run. Zero skip and nonzero skip show whether the gap is added only at run boundaries. Jobs in both directions show whether the roles swap while the arithmetic stays the same. A zero-count job, a job that wraps the main-memory pointer past the top of the address space, and a second `start` issued in the middle of a job test the completion timing and the requirement that a start is ignored while busy.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned ILV_AW       = 32;
    localparam int unsigned ILV_QW       = 16;
    localparam int unsigned ILV_QW_BYTES = 16;
    localparam int unsigned ILV_QW_SHIFT = $clog2(ILV_QW_BYTES);

    typedef logic [ILV_AW-1:0] addr_t;
    typedef logic [ILV_QW-1:0] qwc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_FIRE
    } ilv_state_e;

    typedef struct packed {
        logic dir;
        qwc_t total;
        qwc_t run;
        qwc_t skip;
    } ilv_shape_t;

    typedef struct packed {
        logic valid;
        logic run_end;
        logic job_end;
    } ilv_beat_t;

    function automatic qwc_t eff_run(input qwc_t run, input qwc_t total);
        return (run == '0) ? total : run;
    endfunction

    function automatic qwc_t min_qwc(input qwc_t a, input qwc_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic addr_t qw_bytes(input qwc_t n);
        return addr_t'(n) << ILV_QW_SHIFT;
    endfunction

endpackage

// File: rtl/ilv_run_ctrl.sv
module ilv_run_ctrl
    import ilv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  ilv_shape_t shape_in,
    input  logic       timer_zero,
    output ilv_state_e state,
    output logic       accept,
    output ilv_beat_t  beat,
    output ilv_shape_t shape_q,
    output qwc_t       remain
);

    qwc_t beats_left;
    qwc_t run_len;
    qwc_t rem_after;
    qwc_t next_run;
    qwc_t first_run;

    always_comb begin
        accept       = start && (state == ST_IDLE);
        first_run    = min_qwc(eff_run(shape_in.run, shape_in.total), shape_in.total);
        rem_after    = remain - run_len;
        next_run     = min_qwc(eff_run(shape_q.run, shape_q.total), rem_after);
        beat.valid   = (state == ST_RUN);
        beat.run_end = beat.valid && (beats_left == qwc_t'(1));
        beat.job_end = beat.run_end && (rem_after == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            shape_q    <= '0;
            remain     <= '0;
            beats_left <= '0;
            run_len    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        shape_q    <= shape_in;
                        remain     <= shape_in.total;
                        run_len    <= first_run;
                        beats_left <= first_run;
                        state      <= (shape_in.total == '0) ? ST_WAIT : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (beat.run_end) begin
                        remain <= rem_after;
                        if (beat.job_end) begin
                            state <= ST_WAIT;
                        end else begin
                            run_len    <= next_run;
                            beats_left <= next_run;
                        end
                    end else begin
                        beats_left <= beats_left - qwc_t'(1);
                    end
                end
                ST_WAIT: begin
                    if (timer_zero) begin
                        state <= ST_FIRE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/ilv_ptr_unit.sv
module ilv_ptr_unit
    import ilv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  addr_t mem_in,
    input  addr_t spr_in,
    input  qwc_t  skip_q,
    input  logic  beat_valid,
    input  logic  run_end,
    output addr_t mem_beat,
    output addr_t spr_beat,
    output addr_t chan_mem,
    output addr_t chan_spr
);

    localparam addr_t STEP = addr_t'(ILV_QW_BYTES);

    addr_t mem_next_run;
    addr_t spr_next;

    always_comb begin
        mem_next_run = mem_beat + STEP + qw_bytes(skip_q);
        spr_next     = spr_beat + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_beat <= '0;
            spr_beat <= '0;
            chan_mem <= '0;
            chan_spr <= '0;
        end else if (accept) begin
            mem_beat <= mem_in;
            spr_beat <= spr_in;
            chan_mem <= mem_in;
            chan_spr <= spr_in;
        end else if (beat_valid) begin
            spr_beat <= spr_next;
            if (run_end) begin
                mem_beat <= mem_next_run;
                chan_mem <= mem_next_run;
                chan_spr <= spr_next;
            end else begin
                mem_beat <= mem_beat + STEP;
            end
        end
    end

endmodule

// File: rtl/ilv_delay_timer.sv
module ilv_delay_timer
    import ilv_pkg::*;
#(
    parameter int unsigned DLY_PER_QW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  qwc_t load_qwc,
    input  logic count_en,
    output logic zero
);

    localparam int unsigned DW = ILV_QW + $clog2(DLY_PER_QW + 1) + 1;

    logic [DW-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= DW'(load_qwc) * DW'(DLY_PER_QW);
        end else if (count_en && !zero) begin
            cnt <= cnt - DW'(1);
        end
    end

endmodule

// File: rtl/ilv_stride_agen.sv
module ilv_stride_agen
    import ilv_pkg::*;
#(
    parameter int unsigned DLY_PER_QW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dir,
    input  logic [ILV_QW-1:0]   total_qwc,
    input  logic [ILV_QW-1:0]   run_qwc,
    input  logic [ILV_QW-1:0]   skip_qwc,
    input  logic [ILV_AW-1:0]   mem_addr,
    input  logic [ILV_AW-1:0]   spr_addr,
    output logic                busy,
    output logic                beat_valid,
    output logic [ILV_AW-1:0]   rd_addr,
    output logic [ILV_AW-1:0]   wr_addr,
    output logic [ILV_AW-1:0]   chan_mem,
    output logic [ILV_AW-1:0]   chan_spr,
    output logic [ILV_QW-1:0]   chan_qwc,
    output logic                irq
);

    ilv_shape_t shape_in;
    ilv_shape_t shape_q;
    ilv_state_e state;
    ilv_beat_t  beat;
    logic       accept;
    logic       timer_zero;
    logic       timer_load;
    qwc_t       timer_qwc;
    qwc_t       remain;
    addr_t      mem_beat;
    addr_t      spr_beat;

    always_comb begin
        shape_in.dir   = dir;
        shape_in.total = total_qwc;
        shape_in.run   = run_qwc;
        shape_in.skip  = skip_qwc;
    end

    ilv_run_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .shape_in   (shape_in),
        .timer_zero (timer_zero),
        .state      (state),
        .accept     (accept),
        .beat       (beat),
        .shape_q    (shape_q),
        .remain     (remain)
    );

    ilv_ptr_unit u_ptr (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .mem_in     (mem_addr),
        .spr_in     (spr_addr),
        .skip_q     (shape_q.skip),
        .beat_valid (beat.valid),
        .run_end    (beat.run_end),
        .mem_beat   (mem_beat),
        .spr_beat   (spr_beat),
        .chan_mem   (chan_mem),
        .chan_spr   (chan_spr)
    );

    assign timer_load = accept || beat.job_end;
    assign timer_qwc  = accept ? total_qwc : shape_q.total;

    ilv_delay_timer #(
        .DLY_PER_QW (DLY_PER_QW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_qwc (timer_qwc),
        .count_en (state == ST_WAIT),
        .zero     (timer_zero)
    );

    always_comb begin
        busy       = (state != ST_IDLE);
        beat_valid = beat.valid;
        irq        = (state == ST_FIRE);
        chan_qwc   = remain;
        if (shape_q.dir) begin
            rd_addr = mem_beat;
            wr_addr = spr_beat;
        end else begin
            rd_addr = spr_beat;
            wr_addr = mem_beat;
        end
    end

endmodule

// File: rtl/ilv_stride_agen_chk.sv
module ilv_stride_agen_chk
    import ilv_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  busy,
    input logic  beat_valid,
    input addr_t rd_addr,
    input addr_t wr_addr,
    input logic  dir_q,
    input qwc_t  chan_qwc,
    input logic  irq
);

    addr_t spr_side;
    assign spr_side = dir_q ? wr_addr : rd_addr;

    // R1: nothing happens while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!beat_valid && !irq));

    // R3: remaining count never grows inside a job
    p_qwc_nonincr_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (chan_qwc <= $past(chan_qwc)));

    // R4: scratchpad side is contiguous between consecutive beats
    p_spr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid)) |-> (spr_side == $past(spr_side) + addr_t'(ILV_QW_BYTES)));

    // R7: count register is empty at completion
    p_qwc_zero_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (chan_qwc == '0));

    // R8: interrupt is a single-cycle pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9: interrupt never overlaps a beat and only comes while busy
    p_irq_after_beats_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!beat_valid && busy));

endmodule

bind ilv_stride_agen ilv_stride_agen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .beat_valid (beat_valid),
    .rd_addr    (rd_addr),
    .wr_addr    (wr_addr),
    .dir_q      (shape_q.dir),
    .chan_qwc   (chan_qwc),
    .irq        (irq)
);

// File: tb/tb_ilv_stride_agen.sv
`timescale 1ns/1ps
module tb_ilv_stride_agen;
    import ilv_pkg::*;

    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dir;
    logic [15:0] total_qwc, run_qwc, skip_qwc;
    logic [31:0] mem_addr, spr_addr;
    logic        busy, beat_valid, irq;
    logic [31:0] rd_addr, wr_addr, chan_mem, chan_spr;
    logic [15:0] chan_qwc;

    always #2.5 clk = ~clk;

    ilv_stride_agen #(.DLY_PER_QW(DLY)) dut (
        .clk(clk), .rst(rst), .start(start), .dir(dir),
        .total_qwc(total_qwc), .run_qwc(run_qwc), .skip_qwc(skip_qwc),
        .mem_addr(mem_addr), .spr_addr(spr_addr),
        .busy(busy), .beat_valid(beat_valid), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .chan_mem(chan_mem), .chan_spr(chan_spr), .chan_qwc(chan_qwc), .irq(irq)
    );

    typedef struct {
        logic [31:0] m;
        logic [31:0] s;
        logic [31:0] cm;
        logic [31:0] cs;
        int          cq;
    } beat_t;

    beat_t       q[$];
    int          timer;
    int          job_n;
    bit          job_dir, job_zero, job_run0, started, intruded, prev_irq, was_busy, ended;
    logic [31:0] fin_m, fin_s;
    int          checks = 0;
    int          fails  = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic build_job();
        logic [31:0] m, s;
        int rem, eff, r;
        m = mem_addr; s = spr_addr; rem = int'(total_qwc);
        job_n = rem; job_dir = dir; job_zero = (rem == 0); job_run0 = (run_qwc == 0);
        eff = (run_qwc == 0) ? rem : int'(run_qwc);
        while (rem > 0) begin
            r = (eff < rem) ? eff : rem;
            for (int i = 0; i < r; i++) begin
                beat_t b;
                b.m = m + 32'(i * 16); b.s = s + 32'(i * 16);
                b.cm = m; b.cs = s; b.cq = rem;
                q.push_back(b);
            end
            m = m + 32'((int'(skip_qwc) + r) * 16);
            s = s + 32'(r * 16);
            rem = rem - r;
        end
        fin_m = m; fin_s = s; started = 1'b1;
        if (job_zero) timer = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); timer = -1; prev_irq = 1'b0;
        end else begin
            was_busy = (q.size() > 0) || (timer >= 0);
            prev_irq = (timer == 0);
            if (timer == 0) timer = -1;
            else if (timer > 0) timer--;
            if (q.size() > 0) begin
                void'(q.pop_front());
                if (q.size() == 0) timer = job_n * DLY + 1;
            end else if (!was_busy && start) begin
                build_job();
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (q.size() > 0) begin
                beat_t b;
                b = q[0];
                chk("R3", "beat_valid", 32'(beat_valid), 32'd1);
                chk(job_run0 ? "R2" : "R5", "mem side", job_dir ? rd_addr : wr_addr, b.m);
                chk("R4", "spr side", job_dir ? wr_addr : rd_addr, b.s);
                chk("R6", "rd_addr role", rd_addr, job_dir ? b.m : b.s);
                chk("R3", "chan_qwc", 32'(chan_qwc), 32'(b.cq));
                chk("R12", "chan_mem", chan_mem, b.cm);
                chk("R12", "chan_spr", chan_spr, b.cs);
            end else begin
                chk(job_zero ? "R10" : "R9", "beat_valid idle", 32'(beat_valid), 32'd0);
                if (started) begin
                    chk("R7", "chan_qwc final", 32'(chan_qwc), 32'd0);
                    chk(intruded ? "R11" : "R12", "chan_mem final", chan_mem, fin_m);
                    chk(intruded ? "R11" : "R12", "chan_spr final", chan_spr, fin_s);
                end else begin
                    chk("R1", "chan_qwc", 32'(chan_qwc), 32'd0);
                end
            end
            chk((timer == 0) ? (job_zero ? "R10" : "R9") : (prev_irq ? "R8" : "R9"),
                "irq", 32'(irq), 32'(timer == 0));
            chk("R11", "busy", 32'(busy), 32'((q.size() > 0) || (timer >= 0)));
        end
    end

    task automatic wait_idle();
        while ((q.size() > 0) || (timer >= 0)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic launch(input int n, input int r, input int s, input logic [31:0] m,
                          input logic [31:0] sp, input bit d);
        @(negedge clk);
        total_qwc = 16'(n); run_qwc = 16'(r); skip_qwc = 16'(s);
        mem_addr = m; spr_addr = sp; dir = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_job(input int n, input int r, input int s, input logic [31:0] m,
                           input logic [31:0] sp, input bit d);
        intruded = 1'b0;
        launch(n, r, s, m, sp, d);
        wait_idle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        ended = 1'b1;
        checks++; fails++;
        $display("FAIL watchdog expired actual=busy expected=done");
        summary();
        $finish;
    end

    initial begin
        ended = 1'b0; started = 1'b0; intruded = 1'b0; job_zero = 1'b0;
        job_run0 = 1'b0; job_dir = 1'b0; job_n = 0; timer = -1;
        rst = 1'b1; start = 1'b0; dir = 1'b0;
        total_qwc = '0; run_qwc = '0; skip_qwc = '0; mem_addr = '0; spr_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "beat_valid in reset", 32'(beat_valid), 32'd0);
        chk("R1", "irq in reset", 32'(irq), 32'd0);
        chk("R1", "chan_qwc in reset", 32'(chan_qwc), 32'd0);
        chk("R1", "chan_mem in reset", chan_mem, 32'd0);
        chk("R1", "chan_spr in reset", chan_spr, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_job(10, 3, 2, 32'h0000_1000, 32'h0000_0040, 1'b1);  // uneven last run
        run_job(7, 4, 0, 32'h0002_0000, 32'h0000_0200, 1'b0);   // no gap, reverse dir
        run_job(5, 0, 5, 32'h0000_3000, 32'h0000_0000, 1'b1);   // R2 whole count
        run_job(6, 20, 3, 32'h0000_4000, 32'h0000_0100, 1'b0);  // run longer than count
        run_job(0, 2, 1, 32'h0000_5000, 32'h0000_0300, 1'b1);   // R10 zero count
        run_job(4, 1, 1, 32'h0000_6000, 32'h0000_0010, 1'b1);   // single-quadword runs
        run_job(6, 2, 1, 32'hFFFF_FFC0, 32'h0000_0800, 1'b0);   // pointer wrap

        // R11: second start while busy is ignored
        intruded = 1'b0;
        launch(8, 2, 3, 32'h0000_7000, 32'h0000_0400, 1'b1);
        intruded = 1'b1;
        repeat (2) @(negedge clk);
        launch(3, 1, 9, 32'h0009_0000, 32'h0000_0F00, 1'b0);
        wait_idle();

        run_job(3, 3, 4, 32'h0000_8000, 32'h0000_0500, 1'b0);   // single full run
        ended = 1'b1;
        summary();
        $finish;
    end

endmodule